// File: doc/BRIEF.md
# USB Device Interrupt Status Register

This block collects service requests for a small USB device controller that has a control endpoint, one receive endpoint and one transmit endpoint. Single-cycle event pulses arrive from the receive path, the transmit path and the bus-state detector. Four level flags arrive from the control endpoint's logic. Each request latches into its own sticky status bit unless the matching bit of an externally supplied mask vector blocks it. A set status bit stays set until software clears it.

Software reads the status register through a simple strobe interface. It clears chosen bits by writing ones to their positions. A single interrupt line stays high while any status bit is set. The control-endpoint request comes from edge detection on registered copies of the four flags. A small read-response machine with two states, `RD_IDLE` and `RD_DRIVE`, returns read data one cycle after the strobe. The machine moves from `RD_IDLE` to `RD_DRIVE` on a selected read strobe. It stays in `RD_DRIVE` while selected read strobes continue, and returns to `RD_IDLE` otherwise.

Top module: `usb_dev_irq_stat`

## Requirements
- R1: Status bit positions are fixed as follows: bit 0 is the control endpoint, bit 1 the receive pulse `rx_evt_i`, bit 2 the transmit pulse `tx_evt_i`, bit 3 the suspend pulse `susp_evt_i`, bit 4 the resume pulse `resm_evt_i` and bit 5 the bus-reset pulse `busrst_evt_i`. A pulse that is high at a clock edge sets its bit at that edge.
- R2: After reset every status bit is 0. Bits 7 and 6 of the read data are always 0, even after a write of ones to them.
- R3: When `evt_mask_i[n]` is 1, the event for bit n leaves that bit unchanged.
- R4: When `reg_sel_i` and `wr_i` are both high, each status bit whose `wdata_i` bit is 1 is cleared. Bits written as 0 keep their value. A write with `reg_sel_i` low has no effect.
- R5: `irq_o` is 1 exactly when at least one status bit is 1.
- R6: The control-endpoint flags are `ep0_flags_i[0]` (output packet ready), `[1]` (input packet ready), `[2]` (data end) and `[3]` (setup end). Bit 0 is set by a 0-to-1 change of flag 0 or flag 3, or by a 1-to-0 change of flag 1 or flag 2. Changes in the opposite direction set nothing. The bit reads back set two clock edges after the flag changes.
- R7: If a set event and a write-one clear reach the same bit at the same edge, the bit ends up set.
- R8: Setting a mask bit does not clear a status bit that is already set.
- R9: A read with `reg_sel_i` and `rd_i` high places the status value seen at that edge on `rdata_o` for the following cycle. In every other cycle `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ep0_flags_i | input | 4 | Control endpoint flags, level |
| rx_evt_i | input | 1 | Receive endpoint service pulse |
| tx_evt_i | input | 1 | Transmit endpoint service pulse |
| susp_evt_i | input | 1 | Suspend detected pulse |
| resm_evt_i | input | 1 | Resume detected pulse |
| busrst_evt_i | input | 1 | Host bus reset detected pulse |
| evt_mask_i | input | 6 | Per-bit set mask, 1 blocks setting |
| reg_sel_i | input | 1 | Address decode hit for this register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data, ones clear bits |
| rdata_o | output | 8 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear that lands at the same edge as a new set. For the control endpoint this is harder still, because its set comes from a flag change two edges earlier. The stimulus drives a receive pulse together with a clearing write in the same cycle. It then toggles a control flag and places the clearing write exactly two edges later, so that both requests meet at one edge. A behavioural model in the bench follows every edge, so it also catches a set that is missed or arrives one cycle off.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
    localparam int NUM_EVT  = 6;
    localparam int REG_W    = 8;
    localparam int NUM_FLAG = 4;
    localparam int EV_EP0   = 0;
    localparam int EV_RX    = 1;
    localparam int EV_TX    = 2;
    localparam int EV_SUSP  = 3;
    localparam int EV_RESM  = 4;
    localparam int EV_BRST  = 5;
    // 1 = request on rising edge of that flag, 0 = on falling edge
    localparam logic [NUM_FLAG-1:0] EP0_RISE_SEL = 4'b1001;

    typedef enum logic [0:0] {
        RD_IDLE  = 1'b0,
        RD_DRIVE = 1'b1
    } rd_state_t;
endpackage

// File: rtl/usbirq_ep0_edge.sv
module usbirq_ep0_edge #(
    parameter int                  NFLAG    = 4,
    parameter logic [NFLAG-1:0]    RISE_SEL = 4'b1001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flags_i,
    output logic             pulse_o
);
    logic [NFLAG-1:0] cur_q;
    logic [NFLAG-1:0] old_q;
    logic [NFLAG-1:0] hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
            old_q <= '0;
        end else begin
            cur_q <= flags_i;
            old_q <= cur_q;
        end
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        if (RISE_SEL[g]) begin : g_rise
            assign hit[g] = cur_q[g] & ~old_q[g];
        end else begin : g_fall
            assign hit[g] = ~cur_q[g] & old_q[g];
        end
    end

    always_comb pulse_o = |hit;

    AST_EP0_OPR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q[0]) |-> pulse_o); // R6
    AST_EP0_IPR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_q[1]) |-> pulse_o); // R6
endmodule

// File: rtl/usbirq_status.sv
module usbirq_status #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;
    logic [W-1:0] set_en;

    always_comb set_en = set_i & ~mask_i;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          stat_q[b] <= 1'b0;
            else if (set_en[b])  stat_q[b] <= 1'b1;
            else if (clr_i[b])   stat_q[b] <= 1'b0;
        end

        AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_q[b]) |-> $past(set_i[b] && !mask_i[b])); // R3
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !set_i[b]) |=> !stat_q[b]); // R4
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[b] && !mask_i[b]) |=> stat_q[b]); // R7
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[b] && !clr_i[b]) |=> stat_q[b]); // R8
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/usbirq_regif.sv
module usbirq_regif
    import usbirq_pkg::*;
#(
    parameter int DW = 8,
    parameter int W  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [W-1:0]  stat_i,
    output logic [W-1:0]  clr_o,
    output logic [DW-1:0] rdata_o
);
    localparam int PAD = DW - W;

    rd_state_t    state_q, state_d;
    logic [W-1:0] snap_q;
    logic         rd_hit;
    logic         unused_rsvd;

    always_comb rd_hit = sel_i & rd_i;
    always_comb clr_o  = (sel_i & wr_i) ? wdata_i[W-1:0] : '0;
    assign unused_rsvd = ^wdata_i[DW-1:W];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (rd_hit)  state_d = RD_DRIVE;
            RD_DRIVE: if (!rd_hit) state_d = RD_IDLE;
            default:  state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (rd_hit) snap_q <= stat_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (state_q)
            RD_IDLE:  rdata_o = '0;
            RD_DRIVE: rdata_o = {{PAD{1'b0}}, snap_q};
            default:  rdata_o = '0;
        endcase
    end

    AST_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && rd_i) |=> (rdata_o == {{PAD{1'b0}}, $past(stat_i)})); // R9
    AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_i && rd_i) |=> (rdata_o == '0)); // R9
endmodule

// File: rtl/usb_dev_irq_stat.sv
module usb_dev_irq_stat
    import usbirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_FLAG-1:0] ep0_flags_i,
    input  logic                rx_evt_i,
    input  logic                tx_evt_i,
    input  logic                susp_evt_i,
    input  logic                resm_evt_i,
    input  logic                busrst_evt_i,
    input  logic [NUM_EVT-1:0]  evt_mask_i,
    input  logic                reg_sel_i,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [REG_W-1:0]    wdata_i,
    output logic [REG_W-1:0]    rdata_o,
    output logic                irq_o
);
    logic               ep0_pulse;
    logic [NUM_EVT-1:0] set_vec;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] stat;

    usbirq_ep0_edge #(
        .NFLAG    (NUM_FLAG),
        .RISE_SEL (EP0_RISE_SEL)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (ep0_flags_i),
        .pulse_o (ep0_pulse)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[EV_EP0]  = ep0_pulse;
        set_vec[EV_RX]   = rx_evt_i;
        set_vec[EV_TX]   = tx_evt_i;
        set_vec[EV_SUSP] = susp_evt_i;
        set_vec[EV_RESM] = resm_evt_i;
        set_vec[EV_BRST] = busrst_evt_i;
    end

    usbirq_status #(.W(NUM_EVT)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .mask_i (evt_mask_i),
        .clr_i  (clr_vec),
        .stat_o (stat)
    );

    usbirq_regif #(.DW(REG_W), .W(NUM_EVT)) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (reg_sel_i),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .wdata_i (wdata_i),
        .stat_i  (stat),
        .clr_o   (clr_vec),
        .rdata_o (rdata_o)
    );

    always_comb irq_o = |stat;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec == '0 && set_vec == '0) |=> $stable(irq_o)); // R5
endmodule

// File: tb/usb_dev_irq_stat_test.sv
module usb_dev_irq_stat_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] flags = '0;
    logic       rx = 0, tx = 0, susp = 0, resm = 0, brst = 0;
    logic [5:0] mask = '0;
    logic       sel = 0, wr = 0, rd = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    string cur_req = "R2";

    // behavioural reference model
    int m_stat = 0;
    int m_rdat = 0;
    int m_f1 = 0, m_f2 = 0;

    always #2.5 clk = ~clk;

    usb_dev_irq_stat uut (
        .clk(clk), .rst_n(rst_n), .ep0_flags_i(flags),
        .rx_evt_i(rx), .tx_evt_i(tx), .susp_evt_i(susp),
        .resm_evt_i(resm), .busrst_evt_i(brst), .evt_mask_i(mask),
        .reg_sel_i(sel), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = 0; m_rdat = 0; m_f1 = 0; m_f2 = 0;
        end else begin
            int e0, sets, clr;
            e0 = 0;
            if ((m_f1 & 1) && !(m_f2 & 1)) e0 = 1;
            if (!(m_f1 & 2) && (m_f2 & 2)) e0 = 1;
            if (!(m_f1 & 4) && (m_f2 & 4)) e0 = 1;
            if ((m_f1 & 8) && !(m_f2 & 8)) e0 = 1;
            sets = e0 | (rx << 1) | (tx << 2) | (susp << 3) | (resm << 4) | (brst << 5);
            sets = sets & ~int'(mask) & 63;
            m_rdat = (sel && rd) ? m_stat : 0;
            clr = (sel && wr) ? (int'(wdata) & 63) : 0;
            m_stat = (m_stat & ~clr) | sets;
            m_f2 = m_f1;
            m_f1 = int'(flags);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (int'(rdata) != m_rdat) begin
                errors++;
                $display("FAIL %s per-cycle rdata: actual %02h expected %02h", cur_req, rdata, m_rdat[7:0]);
            end
            checks++;
            if (irq != (m_stat != 0)) begin
                errors++;
                $display("FAIL R5 per-cycle irq: actual %0b expected %0b", irq, m_stat != 0);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic read_chk(input string req, input int exp);
        @(negedge clk); sel = 1; rd = 1;
        @(negedge clk); sel = 0; rd = 0;
        chk(req, int'(rdata), exp);
    endtask

    task automatic wr_reg(input logic s, input logic [7:0] v);
        @(negedge clk); sel = s; wr = 1; wdata = v;
        @(negedge clk); sel = 0; wr = 0; wdata = '0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        case (idx)
            1: rx = 1; 2: tx = 1; 3: susp = 1; 4: resm = 1; 5: brst = 1;
            default: ;
        endcase
        @(negedge clk); rx = 0; tx = 0; susp = 0; resm = 0; brst = 0;
    endtask

    task automatic set_flags(input logic [3:0] v);
        @(negedge clk); flags = v;
        idle(2);
    endtask

    initial begin
        fork
            begin
                idle(3);
                rst_n = 1;
                cur_req = "R2";
                @(negedge clk);
                chk("R2 reset status", int'(rdata), 0);
                chk("R5 reset irq", int'(irq), 0);
                read_chk("R2 reset read", 0);

                cur_req = "R1";
                for (int i = 1; i < 6; i++) begin
                    pulse(i);
                    read_chk("R1 bit position", 1 << i);
                    chk("R5 irq high", int'(irq), 1);
                    wr_reg(1, 8'(1 << i));
                    read_chk("R4 clear by one", 0);
                end

                cur_req = "R4";
                pulse(2); pulse(4);
                wr_reg(1, 8'h00);
                read_chk("R4 zero write keeps", 8'h14);
                wr_reg(0, 8'hFF);
                read_chk("R4 unselected write ignored", 8'h14);
                wr_reg(1, 8'h04);
                read_chk("R4 partial clear", 8'h10);
                wr_reg(1, 8'h10);
                chk("R5 irq low after clear", int'(irq), 0);

                cur_req = "R3";
                mask = 6'b000010;
                pulse(1);
                read_chk("R3 masked rx", 0);
                chk("R3 irq stays low", int'(irq), 0);
                pulse(3);
                read_chk("R3 unmasked neighbour", 8'h08);
                wr_reg(1, 8'h08);
                mask = 6'b000001;
                set_flags(4'b0001);
                read_chk("R3 masked ep0", 0);
                set_flags(4'b0000);
                mask = '0;

                cur_req = "R8";
                pulse(2);
                @(negedge clk); mask = 6'b000100;
                read_chk("R8 mask keeps set bit", 8'h04);
                wr_reg(1, 8'h04);
                mask = '0;

                cur_req = "R6";
                set_flags(4'b0001);
                read_chk("R6 opr rise", 8'h01);
                wr_reg(1, 8'h01);
                set_flags(4'b0000);
                read_chk("R6 opr fall no set", 0);
                set_flags(4'b0010);
                read_chk("R6 ipr rise no set", 0);
                set_flags(4'b0000);
                read_chk("R6 ipr fall", 8'h01);
                wr_reg(1, 8'h01);
                set_flags(4'b0100);
                read_chk("R6 de rise no set", 0);
                set_flags(4'b0000);
                read_chk("R6 de fall", 8'h01);
                wr_reg(1, 8'h01);
                set_flags(4'b1000);
                read_chk("R6 se rise", 8'h01);
                wr_reg(1, 8'h01);
                set_flags(4'b0000);
                read_chk("R6 se fall no set", 0);
                // latency: flag change, then status visible after two edges
                @(negedge clk); flags = 4'b0001;
                @(negedge clk); chk("R6 not yet after one edge", int'(irq), 0);
                @(negedge clk); chk("R6 set after two edges", int'(irq), 1);
                wr_reg(1, 8'h01);
                flags = 4'b0000;
                idle(2);

                cur_req = "R7";
                @(negedge clk); rx = 1; sel = 1; wr = 1; wdata = 8'h02;
                @(negedge clk); rx = 0; sel = 0; wr = 0; wdata = 0;
                read_chk("R7 rx set beats clear", 8'h02);
                @(negedge clk); rx = 1; sel = 1; wr = 1; wdata = 8'h02;
                @(negedge clk); rx = 0; sel = 0; wr = 0; wdata = 0;
                read_chk("R7 set beats clear on set bit", 8'h02);
                wr_reg(1, 8'h02);
                @(negedge clk); flags = 4'b1000;
                @(negedge clk); sel = 1; wr = 1; wdata = 8'h01;
                @(negedge clk); sel = 0; wr = 0; wdata = 0;
                read_chk("R7 ep0 set beats clear", 8'h01);
                wr_reg(1, 8'h01);
                flags = 4'b0000;
                idle(2);

                cur_req = "R2";
                @(negedge clk); rx = 1; tx = 1; susp = 1; resm = 1; brst = 1; flags = 4'b0001;
                @(negedge clk); rx = 0; tx = 0; susp = 0; resm = 0; brst = 0;
                idle(2);
                read_chk("R2 all set, reserved zero", 8'h3F);
                wr_reg(1, 8'hC0);
                read_chk("R2 reserved write no effect", 8'h3F);
                wr_reg(1, 8'hFF);
                flags = 4'b0000;
                idle(2);

                cur_req = "R9";
                @(negedge clk); sel = 0; rd = 1;
                @(negedge clk); rd = 0;
                chk("R9 unselected read gives zero", int'(rdata), 0);
                pulse(5);
                @(negedge clk); sel = 1; rd = 1;
                @(negedge clk);
                chk("R9 back-to-back read 1", int'(rdata), 8'h20);
                @(negedge clk); sel = 0; rd = 0;
                chk("R9 back-to-back read 2", int'(rdata), 8'h20);
                @(negedge clk);
                chk("R9 data drops after read", int'(rdata), 0);
                idle(3);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule